// File: doc/BRIEF.md
# Multi-width aliased register file

This block holds sixteen general-purpose 64-bit registers. Any register can be reached through several overlapping windows: the whole 64-bit word, its low 32 bits, or its low 16 bits. Registers 0 to 3 also offer two single-byte windows, one on bits 7:0 and one on bits 15:8. Every access names a register index, a window code and a byte-half select. Read data always comes back right-aligned and zero-extended to 64 bits.

There are two combinational read ports and one write port that commits on the rising clock edge. A narrow write merges into the stored word according to fixed rules. A byte access to a register that has no byte window is refused and flagged on the same cycle.

Top module: `multiwidth_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero.
- R2: Window code 0 (full) reads the whole 64-bit word, and a write through it replaces the whole word.
- R3: Window code 1 (dword) reads bits 31:0 zero-extended. A write through it stores bits 31:0 and clears bits 63:32.
- R4: Window code 2 (word) reads bits 15:0 zero-extended. A write through it changes bits 15:0 only and keeps bits 63:16.
- R5: Window code 3 (byte) on registers 0 to 3 selects bits 7:0 when the half select is 0 and bits 15:8 when it is 1. Read data appears in bits 7:0 of the result. A write changes only the addressed byte, taking it from write-data bits 7:0.
- R6: A byte-window access to registers 4 to 15 is illegal and raises that port's illegal flag in the same cycle. An illegal read returns zero, and an illegal write changes no register.
- R7: The half select has no effect for window codes 0, 1 and 2.
- R8: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle.
- R9: The two read ports are independent and may address different registers and windows in the same cycle.
- R10: With write enable low, no register changes and the write illegal flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_view | input | 2 | Write window code |
| wr_hi | input | 1 | Write byte-half select |
| wr_data | input | 64 | Write data, right-aligned |
| wr_illegal | output | 1 | Write request refused |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_view | input | 2 | Read port 0 window code |
| rd0_hi | input | 1 | Read port 0 byte-half select |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 request refused |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_view | input | 2 | Read port 1 window code |
| rd1_hi | input | 1 | Read port 1 byte-half select |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 request refused |

## Verification
The bench targets the merge rules for narrow writes:
- If the dword write did not clear bits 63:32, the old upper half would survive.
- If the word or byte write zero-filled its register, the surrounding bits would be lost.
- If the byte-half select were swapped, data would land in the wrong byte.

It also aims byte accesses at registers 4, 5, 7 and 15. A design that decoded the legality boundary wrongly would corrupt those registers or return non-zero data. It reads a register while writing the same register. A write-through bypass would show the new value one cycle early. It also drives the half select with wide windows and toggles write data while write enable is low.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int RF_XLEN      = 64;
    localparam int RF_NREG      = 16;
    localparam int RF_BYTE_REGS = 4;

    typedef enum logic [1:0] {
        VIEW_FULL  = 2'd0,
        VIEW_DWORD = 2'd1,
        VIEW_WORD  = 2'd2,
        VIEW_BYTE  = 2'd3
    } view_e;

    // True when a byte window is requested on a register that has none.
    function automatic logic byte_view_illegal(input int unsigned idx,
                                               input view_e view,
                                               input int unsigned byte_regs);
        return (view == VIEW_BYTE) && (idx >= byte_regs);
    endfunction

endpackage

// File: rtl/rf_view_decode.sv
module rf_view_decode
    import regfile_pkg::*;
#(
    parameter int XLEN      = RF_XLEN,
    parameter int NREG      = RF_NREG,
    parameter int BYTE_REGS = RF_BYTE_REGS,
    localparam int IDXW     = $clog2(NREG)
) (
    input  logic [XLEN-1:0] word,
    input  logic [IDXW-1:0] idx,
    input  view_e           view,
    input  logic            hi,
    output logic [XLEN-1:0] data,
    output logic            illegal
);

    always_comb begin
        illegal = byte_view_illegal(int'(idx), view, BYTE_REGS);
        data    = '0;
        if (!illegal) begin
            unique case (view)
                VIEW_FULL:  data = word;
                VIEW_DWORD: data[31:0] = word[31:0];
                VIEW_WORD:  data[15:0] = word[15:0];
                VIEW_BYTE:  data[7:0]  = hi ? word[15:8] : word[7:0];
                default:    data = '0;
            endcase
        end
    end

endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
    import regfile_pkg::*;
#(
    parameter int XLEN = RF_XLEN
) (
    input  logic [XLEN-1:0] old_word,
    input  logic [XLEN-1:0] wdata,
    input  view_e           view,
    input  logic            hi,
    output logic [XLEN-1:0] new_word
);

    always_comb begin
        new_word = old_word;
        unique case (view)
            VIEW_FULL:  new_word = wdata;
            VIEW_DWORD: new_word = {{(XLEN-32){1'b0}}, wdata[31:0]};
            VIEW_WORD:  new_word[15:0] = wdata[15:0];
            VIEW_BYTE: begin
                if (hi) new_word[15:8] = wdata[7:0];
                else    new_word[7:0]  = wdata[7:0];
            end
            default:    new_word = old_word;
        endcase
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import regfile_pkg::*;
#(
    parameter int XLEN  = RF_XLEN,
    parameter int NREG  = RF_NREG,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDXW-1:0]           widx,
    input  logic [XLEN-1:0]           wword,
    output logic [NREG-1:0][XLEN-1:0] regs
);

    always_ff @(posedge clk) begin
        if (rst)     regs       <= '0;
        else if (we) regs[widx] <= wword;
    end

endmodule

// File: rtl/multiwidth_regfile.sv
module multiwidth_regfile
    import regfile_pkg::*;
#(
    parameter int XLEN      = RF_XLEN,
    parameter int NREG      = RF_NREG,
    parameter int BYTE_REGS = RF_BYTE_REGS,
    localparam int IDXW     = $clog2(NREG),
    localparam int NRD      = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [1:0]      wr_view,
    input  logic            wr_hi,
    input  logic [XLEN-1:0] wr_data,
    output logic            wr_illegal,
    input  logic [IDXW-1:0] rd0_idx,
    input  logic [1:0]      rd0_view,
    input  logic            rd0_hi,
    output logic [XLEN-1:0] rd0_data,
    output logic            rd0_illegal,
    input  logic [IDXW-1:0] rd1_idx,
    input  logic [1:0]      rd1_view,
    input  logic            rd1_hi,
    output logic [XLEN-1:0] rd1_data,
    output logic            rd1_illegal
);

    logic [NREG-1:0][XLEN-1:0] regs_q;
    logic [XLEN-1:0]           merged;
    logic                      commit;

    logic [IDXW-1:0] rp_idx  [NRD];
    view_e           rp_view [NRD];
    logic            rp_hi   [NRD];
    logic [XLEN-1:0] rp_data [NRD];
    logic            rp_ill  [NRD];

    assign rp_idx[0]  = rd0_idx;
    assign rp_view[0] = view_e'(rd0_view);
    assign rp_hi[0]   = rd0_hi;
    assign rp_idx[1]  = rd1_idx;
    assign rp_view[1] = view_e'(rd1_view);
    assign rp_hi[1]   = rd1_hi;

    // Combinational read ports, one decoder each.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rf_view_decode #(.XLEN(XLEN), .NREG(NREG), .BYTE_REGS(BYTE_REGS)) u_dec (
            .word    (regs_q[rp_idx[p]]),
            .idx     (rp_idx[p]),
            .view    (rp_view[p]),
            .hi      (rp_hi[p]),
            .data    (rp_data[p]),
            .illegal (rp_ill[p])
        );
    end

    assign rd0_data    = rp_data[0];
    assign rd0_illegal = rp_ill[0];
    assign rd1_data    = rp_data[1];
    assign rd1_illegal = rp_ill[1];

    // Write path: legality check, merge, commit.
    assign wr_illegal = wr_en && byte_view_illegal(int'(wr_idx), view_e'(wr_view), BYTE_REGS);
    assign commit     = wr_en && !wr_illegal;

    rf_write_merge #(.XLEN(XLEN)) u_merge (
        .old_word (regs_q[wr_idx]),
        .wdata    (wr_data),
        .view     (view_e'(wr_view)),
        .hi       (wr_hi),
        .new_word (merged)
    );

    rf_storage #(.XLEN(XLEN), .NREG(NREG)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .widx  (wr_idx),
        .wword (merged),
        .regs  (regs_q)
    );

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int XLEN  = 64,
    parameter int NREG  = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NREG-1:0][XLEN-1:0] regs_q,
    input logic                      wr_en,
    input logic [IDXW-1:0]           wr_idx,
    input logic [1:0]                wr_view,
    input logic                      wr_illegal,
    input logic [XLEN-1:0]           rd0_data,
    input logic                      rd0_illegal,
    input logic [XLEN-1:0]           rd1_data,
    input logic                      rd1_illegal
);

    logic past_rst_q;
    always_ff @(posedge clk) past_rst_q <= rst;

    always_ff @(posedge clk) begin
        if (past_rst_q === 1'b1)
            assert_reset_clear_R1: assert (regs_q == '0);
    end

    always_comb begin
        if (rd0_illegal) assert_illegal_rd0_zero_R6: assert (rd0_data == '0);
        if (rd1_illegal) assert_illegal_rd1_zero_R6: assert (rd1_data == '0);
    end

    assert_dword_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_illegal && wr_view == 2'd1)
        |=> regs_q[$past(wr_idx)][XLEN-1:32] == '0);

    assert_word_keep_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_illegal && wr_view == 2'd2)
        |=> regs_q[$past(wr_idx)][XLEN-1:16] == $past(regs_q[wr_idx][XLEN-1:16]));

    assert_byte_keep_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_illegal && wr_view == 2'd3)
        |=> regs_q[$past(wr_idx)][XLEN-1:16] == $past(regs_q[wr_idx][XLEN-1:16]));

    assert_illegal_write_hold_R6: assert property (@(posedge clk) disable iff (rst)
        wr_illegal |=> $stable(regs_q));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));

endmodule

bind multiwidth_regfile rf_checker #(.XLEN(XLEN), .NREG(NREG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .regs_q      (regs_q),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_view     (wr_view),
    .wr_illegal  (wr_illegal),
    .rd0_data    (rd0_data),
    .rd0_illegal (rd0_illegal),
    .rd1_data    (rd1_data),
    .rd1_illegal (rd1_illegal)
);

// File: tb/sim_multiwidth_regfile.sv
`timescale 1ns/1ps
module sim_multiwidth_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [1:0]  wr_view;
    logic        wr_hi;
    logic [63:0] wr_data;
    logic        wr_illegal;
    logic [3:0]  rd0_idx, rd1_idx;
    logic [1:0]  rd0_view, rd1_view;
    logic        rd0_hi, rd1_hi;
    logic [63:0] rd0_data, rd1_data;
    logic        rd0_illegal, rd1_illegal;

    always #5 clk = ~clk;

    multiwidth_regfile u0 (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_hi(wr_hi),
        .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_hi(rd0_hi),
        .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
        .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_hi(rd1_hi),
        .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
    );

    typedef struct packed {
        logic [63:0] d0;
        logic        i0;
        logic [63:0] d1;
        logic        i1;
        logic        wi;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [63:0] mdl [16];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model written from the requirements.
    function automatic logic illegal_m(input logic [3:0] idx, input logic [1:0] v);
        return (v == 2'd3) && (idx >= 4'd4);
    endfunction

    function automatic logic [63:0] read_m(input logic [3:0] idx, input logic [1:0] v, input logic h);
        logic [63:0] w;
        w = mdl[idx];
        if (illegal_m(idx, v)) return 64'd0;
        case (v)
            2'd0:    return w;
            2'd1:    return {32'd0, w[31:0]};
            2'd2:    return {48'd0, w[15:0]};
            default: return {56'd0, (h ? w[15:8] : w[7:0])};
        endcase
    endfunction

    task automatic op(input string tag,
                      input logic we, input logic [3:0] wi, input logic [1:0] wv,
                      input logic wh, input logic [63:0] wd,
                      input logic [3:0] a, input logic [1:0] av, input logic ah,
                      input logic [3:0] b, input logic [1:0] bv, input logic bh);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_view = wv; wr_hi = wh; wr_data = wd;
        rd0_idx = a; rd0_view = av; rd0_hi = ah;
        rd1_idx = b; rd1_view = bv; rd1_hi = bh;
        e.d0 = read_m(a, av, ah); e.i0 = illegal_m(a, av);
        e.d1 = read_m(b, bv, bh); e.i1 = illegal_m(b, bv);
        e.wi = we && illegal_m(wi, wv);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (we && !illegal_m(wi, wv)) begin
            case (wv)
                2'd0: mdl[wi] = wd;
                2'd1: mdl[wi] = {32'd0, wd[31:0]};
                2'd2: mdl[wi][15:0] = wd[15:0];
                default: if (wh) mdl[wi][15:8] = wd[7:0]; else mdl[wi][7:0] = wd[7:0];
            endcase
        end
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [1:0] av, input logic ah,
                      input logic [3:0] b, input logic [1:0] bv, input logic bh);
        op(tag, 1'b0, 4'd0, 2'd0, 1'b0, 64'd0, a, av, ah, b, bv, bh);
    endtask

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Monitor: samples combinational outputs mid-cycle, before the next edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                cmp(t, "rd0_data", rd0_data, e.d0);
                cmp(t, "rd0_illegal", {63'd0, rd0_illegal}, {63'd0, e.i0});
                cmp(t, "rd1_data", rd1_data, e.d1);
                cmp(t, "rd1_illegal", {63'd0, rd1_illegal}, {63'd0, e.i1});
                cmp(t, "wr_illegal", {63'd0, wr_illegal}, {63'd0, e.wi});
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                checks++; fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_hi = 1'b0; wr_data = '0;
        rd0_idx = '0; rd0_view = '0; rd0_hi = 1'b0; rd1_idx = '0; rd1_view = '0; rd1_hi = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: all registers read zero after reset
        for (int i = 0; i < 8; i++)
            rd("R1", 4'(i), 2'd0, 1'b0, 4'(i + 8), 2'd0, 1'b0);

        // R2: full writes then full reads
        for (int i = 0; i < 16; i++)
            op("R2", 1'b1, 4'(i), 2'd0, 1'b0, {8'(i), 56'hA5C3_F00D_1234_56} ^ 64'h0123_4567_89AB_CDEF,
               4'(i), 2'd0, 1'b0, 4'(15 - i), 2'd0, 1'b0);
        for (int i = 0; i < 8; i++)
            rd("R2", 4'(i), 2'd0, 1'b0, 4'(i + 8), 2'd0, 1'b0);

        // R3: dword read and write zero-fills upper half
        rd("R3", 4'd9, 2'd1, 1'b0, 4'd5, 2'd1, 1'b0);
        op("R3", 1'b1, 4'd5, 2'd1, 1'b0, 64'hFFFF_FFFF_8765_4321, 4'd5, 2'd0, 1'b0, 4'd6, 2'd0, 1'b0);
        rd("R3", 4'd5, 2'd0, 1'b0, 4'd5, 2'd1, 1'b0);

        // R4: word write keeps bits 63:16
        op("R4", 1'b1, 4'd6, 2'd2, 1'b0, 64'hDEAD_BEEF_CAFE_BABE, 4'd6, 2'd2, 1'b0, 4'd7, 2'd2, 1'b0);
        rd("R4", 4'd6, 2'd0, 1'b0, 4'd6, 2'd2, 1'b0);

        // R5: low and high byte windows on registers 0..3
        for (int i = 0; i < 4; i++) begin
            op("R5", 1'b1, 4'(i), 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FF00 | 64'(8'h11 * (i + 1)),
               4'(i), 2'd3, 1'b0, 4'(i), 2'd3, 1'b1);
            op("R5", 1'b1, 4'(i), 2'd3, 1'b1, 64'h0000_0000_0000_0000 | 64'(8'h9A + i),
               4'(i), 2'd3, 1'b0, 4'(i), 2'd0, 1'b0);
            rd("R5", 4'(i), 2'd3, 1'b1, 4'(i), 2'd0, 1'b0);
        end

        // R6: byte windows on registers 4..15 are illegal
        op("R6", 1'b1, 4'd4, 2'd3, 1'b0, 64'h55, 4'd5, 2'd3, 1'b1, 4'd4, 2'd3, 1'b0);
        op("R6", 1'b1, 4'd7, 2'd3, 1'b1, 64'h66, 4'd15, 2'd3, 1'b0, 4'd3, 2'd3, 1'b1);
        op("R6", 1'b1, 4'd15, 2'd3, 1'b1, 64'h77, 4'd4, 2'd0, 1'b0, 4'd7, 2'd0, 1'b0);
        rd("R6", 4'd15, 2'd0, 1'b0, 4'd4, 2'd0, 1'b0);

        // R7: half select ignored for wide windows
        op("R7", 1'b1, 4'd8, 2'd2, 1'b1, 64'h1234_5678_9ABC_4E4E, 4'd8, 2'd2, 1'b1, 4'd9, 2'd1, 1'b1);
        op("R7", 1'b1, 4'd10, 2'd1, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 4'd10, 2'd0, 1'b1, 4'd8, 2'd0, 1'b1);
        rd("R7", 4'd10, 2'd0, 1'b1, 4'd8, 2'd0, 1'b0);

        // R8: read during write of the same register returns old value
        op("R8", 1'b1, 4'd11, 2'd0, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 4'd11, 2'd0, 1'b0, 4'd11, 2'd2, 1'b0);
        op("R8", 1'b1, 4'd11, 2'd0, 1'b0, 64'hF0F0_F0F0_F0F0_F0F0, 4'd11, 2'd0, 1'b0, 4'd11, 2'd1, 1'b0);
        rd("R8", 4'd11, 2'd0, 1'b0, 4'd11, 2'd3, 1'b0);

        // R9: two ports, different registers and windows
        rd("R9", 4'd2, 2'd3, 1'b1, 4'd12, 2'd1, 1'b0);
        rd("R9", 4'd13, 2'd2, 1'b0, 4'd1, 2'd3, 1'b0);

        // R10: write enable low leaves state untouched
        op("R10", 1'b0, 4'd12, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd12, 2'd0, 1'b0, 4'd0, 2'd0, 1'b0);
        op("R10", 1'b0, 4'd0, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd12, 2'd0, 1'b0, 4'd0, 2'd0, 1'b0);
        rd("R10", 4'd12, 2'd0, 1'b0, 4'd0, 2'd0, 1'b0);

        // R1: reset mid-run clears everything again
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++)
            rd("R1", 4'(i), 2'd0, 1'b0, 4'(i + 8), 2'd0, 1'b0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule